// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the register side of an SPI master. Software reaches it over a 64-bit register bus. It holds the controller's configuration words, a transmit word, a receive word, eight one-byte sequencer opcodes and a small set of status flags. Every held value is driven out continuously to the shifting engine and the opcode sequencer. Those engines sit outside this block.

A request is a single cycle with `req_valid` high. The register index is the byte address with its three low bits dropped. Data registers have side effects on the status flags when they are accessed. The engine side has two inputs. A load strobe deposits a received word. A consume strobe reports that the transmit word has been taken.

The clock-configuration register also guards a controller reset. Software must write a value whose key field is 0x5, then a value whose key field is 0xA. The second write then loads a fixed hard-reset value instead of the data.

Top module: `spi_regfront`

## Requirements
- R1: After reset, every held register, every status flag and `rd_data_o` are zero.
- R2: A read returns its data on `rd_data_o` one cycle after the request, and `rd_data_o` holds between reads. Indices 0 (error), 1 (counter config), 2 (general config), 4 (memory-mapped config) and 6 (receive data) are plain storage that returns what was last written.
- R3: A read of an index other than 0 to 8 returns all ones. A write to such an index changes no held value.
- R4: Reading index 6 (receive data) clears receive-full (status bit 63).
- R5: Writing index 5 (transmit data) stores the word, sets transmit-full (bit 59) and clears transmit-underrun (bit 57).
- R6: On a write to index 3 (clock config), the register loads the hard-reset value 0 when its bits 27:24 held 0x5 before the write and the written bits 27:24 are 0xA. Every other write to it stores the data unchanged.
- R7: At index 7, write data bits 63:56 are opcode 0 and bits 7:0 are opcode 7. Reads return the same layout. On `seq_opcodes_o`, opcode k appears at bits 8k+7:8k.
- R8: A write to index 8 (status) loads receive-overrun (bit 62) from written bit 63 and transmit-overrun (bit 58) from written bit 59. All other status bits keep their values. A status read shows zero in bits 61:60 and 56:0.
- R9: `eng_tx_consume` clears transmit-full. A consume that arrives while transmit-full is clear sets transmit-underrun.
- R10: `eng_rx_load` stores `eng_rx_data` in the receive register and sets receive-full. If receive-full was already set, it also sets receive-overrun.
- R11: When a bus access and an engine strobe touch the same register or flag in one cycle, the bus access wins. Cases: a transmit write with a consume; a status write with an overrunning load; a receive write with a load; a receive read with a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; index = address >> 3 |
| req_wdata | input | 64 | Write data |
| rd_data_o | output | 64 | Registered read data |
| eng_rx_load | input | 1 | Engine deposits a received word |
| eng_rx_data | input | 64 | Received word |
| eng_tx_consume | input | 1 | Engine has taken the transmit word |
| err_o | output | 64 | Error register |
| ctr_cfg_o | output | 64 | Counter configuration |
| gen_cfg_o | output | 64 | General configuration |
| clk_cfg_o | output | 64 | Clock configuration |
| mm_cfg_o | output | 64 | Memory-mapped configuration |
| tx_data_o | output | 64 | Transmit word |
| rx_data_o | output | 64 | Receive word |
| status_o | output | 64 | Status flags in their register layout |
| seq_opcodes_o | output | 64 | Eight opcodes, opcode k at bits 8k+7:8k |

## Verification
- **Plain registers:** each is loaded with a distinct word and read back. This separates index decode faults from storage faults.
- **Unmapped indices:** reads and writes are tried at the first and at the top unmapped index, so off-by-one decode errors show.
- **Reset key:** the clock-config key is tried with the correct pair, with the halves swapped, and with a wrong second nibble. Only the first may reset.
- **Flags and collisions:** engine strobes are applied alone, repeated (to expose overrun and underrun), and in the same cycle as bus accesses to the same flag. This distinguishes the priority order from plain set and clear logic.
- **Opcode order:** a word with eight different bytes checks the order on both the readback and the exported vector.

// File: rtl/spi_regfront.sv
module spi_regfront #(
  parameter int          ADDR_W       = 8,
  parameter int          KEY_LSB      = 24,
  parameter logic [3:0]  KEY_FIRST    = 4'h5,
  parameter logic [3:0]  KEY_SECOND   = 4'hA,
  parameter logic [63:0] HARD_RST_VAL = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rd_data_o,
  input  logic              eng_rx_load,
  input  logic [63:0]       eng_rx_data,
  input  logic              eng_tx_consume,
  output logic [63:0]       err_o,
  output logic [63:0]       ctr_cfg_o,
  output logic [63:0]       gen_cfg_o,
  output logic [63:0]       clk_cfg_o,
  output logic [63:0]       mm_cfg_o,
  output logic [63:0]       tx_data_o,
  output logic [63:0]       rx_data_o,
  output logic [63:0]       status_o,
  output logic [63:0]       seq_opcodes_o
);
  localparam int IDX_W   = ADDR_W - 3;
  localparam int NUM_OPS = 8;
  localparam logic [IDX_W-1:0] I_ERR = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_CTR = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_CFG = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_CLK = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_MM  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_TX  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_RX  = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_SEQ = IDX_W'(7);
  localparam logic [IDX_W-1:0] I_STS = IDX_W'(8);

  wire [IDX_W-1:0] idx = req_addr[ADDR_W-1:3];
  wire rd = req_valid & ~req_write;
  wire wr = req_valid & req_write;

  logic rx_full, rx_ovr, tx_full, tx_ovr, tx_under;
  logic [7:0]  seq_op [NUM_OPS];
  logic [63:0] seq_word;
  logic [63:0] rd_mux;

  wire key_hit = (clk_cfg_o[KEY_LSB +: 4] == KEY_FIRST) &&
                 (req_wdata[KEY_LSB +: 4] == KEY_SECOND);

  assign status_o = {rx_full, rx_ovr, 2'b00, tx_full, tx_ovr, tx_under, 57'd0};

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    always_ff @(posedge clk) begin
      if (!rst_n)                   seq_op[k] <= '0;
      else if (wr && idx == I_SEQ)  seq_op[k] <= req_wdata[63-8*k -: 8];
    end
    assign seq_word[63-8*k -: 8]  = seq_op[k];
    assign seq_opcodes_o[8*k +: 8] = seq_op[k];
  end

  always_comb begin
    case (idx)
      I_ERR:   rd_mux = err_o;
      I_CTR:   rd_mux = ctr_cfg_o;
      I_CFG:   rd_mux = gen_cfg_o;
      I_CLK:   rd_mux = clk_cfg_o;
      I_MM:    rd_mux = mm_cfg_o;
      I_TX:    rd_mux = tx_data_o;
      I_RX:    rd_mux = rx_data_o;
      I_SEQ:   rd_mux = seq_word;
      I_STS:   rd_mux = status_o;
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_o <= '0;
      err_o     <= '0;
      ctr_cfg_o <= '0;
      gen_cfg_o <= '0;
      clk_cfg_o <= '0;
      mm_cfg_o  <= '0;
      tx_data_o <= '0;
      rx_data_o <= '0;
      rx_full   <= 1'b0;
      rx_ovr    <= 1'b0;
      tx_full   <= 1'b0;
      tx_ovr    <= 1'b0;
      tx_under  <= 1'b0;
    end else begin
      if (rd) rd_data_o <= rd_mux;
      if (wr && idx == I_ERR) err_o     <= req_wdata;
      if (wr && idx == I_CTR) ctr_cfg_o <= req_wdata;
      if (wr && idx == I_CFG) gen_cfg_o <= req_wdata;
      if (wr && idx == I_MM)  mm_cfg_o  <= req_wdata;
      if (wr && idx == I_TX)  tx_data_o <= req_wdata;
      if (wr && idx == I_CLK) clk_cfg_o <= key_hit ? HARD_RST_VAL : req_wdata;

      if (wr && idx == I_RX)  rx_data_o <= req_wdata;
      else if (eng_rx_load)   rx_data_o <= eng_rx_data;

      if (rd && idx == I_RX)  rx_full <= 1'b0;
      else if (eng_rx_load)   rx_full <= 1'b1;

      if (wr && idx == I_STS)          rx_ovr <= req_wdata[63];
      else if (eng_rx_load && rx_full) rx_ovr <= 1'b1;

      if (wr && idx == I_STS) tx_ovr <= req_wdata[59];

      if (wr && idx == I_TX)  tx_full <= 1'b1;
      else if (eng_tx_consume) tx_full <= 1'b0;

      if (wr && idx == I_TX)                tx_under <= 1'b0;
      else if (eng_tx_consume && !tx_full)  tx_under <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int          ADDR_W       = 8,
  parameter int          KEY_LSB      = 24,
  parameter logic [63:0] HARD_RST_VAL = 64'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [63:0]       req_wdata,
  input logic [63:0]       rd_data_o,
  input logic              eng_rx_load,
  input logic              eng_tx_consume,
  input logic [63:0]       clk_cfg_o,
  input logic [63:0]       tx_data_o,
  input logic [63:0]       status_o
);
  localparam int IDX_W = ADDR_W - 3;
  wire [IDX_W-1:0] ix = req_addr[ADDR_W-1:3];
  wire rdq = req_valid && !req_write;
  wire wrq = req_valid && req_write;
  wire unmapped = ix > IDX_W'(8);

  p_unmapped_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && unmapped) |=> rd_data_o == '1);

  p_rx_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && ix == IDX_W'(6)) |=> !status_o[63]);

  p_tx_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrq && ix == IDX_W'(5)) |=> status_o[59] && !status_o[57]
                                  && tx_data_o == $past(req_wdata));

  p_reset_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrq && ix == IDX_W'(3) && clk_cfg_o[KEY_LSB +: 4] == 4'h5
     && req_wdata[KEY_LSB +: 4] == 4'hA) |=> clk_cfg_o == HARD_RST_VAL);

  p_status_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrq && ix == IDX_W'(8)) |=> status_o[62] == $past(req_wdata[63])
                                  && status_o[58] == $past(req_wdata[59])
                                  && status_o[63] == $past(status_o[63]));

  p_rx_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_load && status_o[63] && !(wrq && ix == IDX_W'(8))
     && !(rdq && ix == IDX_W'(6))) |=> status_o[62] && status_o[63]);

  p_tx_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrq && ix == IDX_W'(5) && eng_tx_consume) |=> status_o[59]);
endmodule

bind spi_regfront spi_regfront_chk #(
  .ADDR_W(ADDR_W), .KEY_LSB(KEY_LSB), .HARD_RST_VAL(HARD_RST_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_data_o(rd_data_o),
  .eng_rx_load(eng_rx_load), .eng_tx_consume(eng_tx_consume),
  .clk_cfg_o(clk_cfg_o), .tx_data_o(tx_data_o), .status_o(status_o)
);

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, eng_rx_load = 0, eng_tx_consume = 0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0, eng_rx_data = '0;
  logic [63:0] rd_data_o, err_o, ctr_cfg_o, gen_cfg_o, clk_cfg_o, mm_cfg_o;
  logic [63:0] tx_data_o, rx_data_o, status_o, seq_opcodes_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regfront u_spi_regfront (.*);

  // behavioural reference state
  logic [63:0] m_reg [int];
  logic [63:0] m_rd;
  bit m_rxf, m_rxo, m_txf, m_txo, m_txu;

  function automatic logic [63:0] m_status();
    logic [63:0] s = '0;
    s[63] = m_rxf; s[62] = m_rxo; s[59] = m_txf; s[58] = m_txo; s[57] = m_txu;
    return s;
  endfunction

  function automatic logic [63:0] m_read(int ix);
    if (ix == 8) return m_status();
    if (ix >= 0 && ix < 8) return m_reg[ix];
    return '1;
  endfunction

  function automatic logic [63:0] m_seq_export();
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = m_reg[7][63-8*k -: 8];
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "rd_data", rd_data_o, m_rd);
    chk(tag, "err", err_o, m_reg[0]);
    chk(tag, "ctr_cfg", ctr_cfg_o, m_reg[1]);
    chk(tag, "gen_cfg", gen_cfg_o, m_reg[2]);
    chk(tag, "clk_cfg", clk_cfg_o, m_reg[3]);
    chk(tag, "mm_cfg", mm_cfg_o, m_reg[4]);
    chk(tag, "tx_data", tx_data_o, m_reg[5]);
    chk(tag, "rx_data", rx_data_o, m_reg[6]);
    chk(tag, "status", status_o, m_status());
    chk(tag, "seq_opcodes", seq_opcodes_o, m_seq_export());
  endtask

  task automatic cyc(string tag, bit v, bit w, int ix, logic [63:0] d,
                     bit ld = 0, logic [63:0] ldd = '0, bit cons = 0);
    bit rdq = v && !w, wrq = v && w, old_rxf = m_rxf, old_txf = m_txf;
    req_valid = v; req_write = w; req_addr = 8'(ix << 3) | 8'(ix & 3);
    req_wdata = d; eng_rx_load = ld; eng_rx_data = ldd; eng_tx_consume = cons;
    if (rdq) m_rd = m_read(ix);
    if (wrq && ix inside {0, 1, 2, 4, 5, 7}) m_reg[ix] = d;
    if (wrq && ix == 3)
      m_reg[3] = (m_reg[3][27:24] == 4'h5 && d[27:24] == 4'hA) ? 64'h0 : d;
    if (wrq && ix == 6) m_reg[6] = d; else if (ld) m_reg[6] = ldd;
    if (rdq && ix == 6) m_rxf = 0; else if (ld) m_rxf = 1;
    if (wrq && ix == 8) begin m_rxo = d[63]; m_txo = d[59]; end
    else if (ld && old_rxf) m_rxo = 1;
    if (wrq && ix == 5) begin m_txf = 1; m_txu = 0; end
    else if (cons) begin m_txf = 0; if (!old_txf) m_txu = 1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0; eng_rx_load = 0; eng_tx_consume = 0;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");

    // R2 plain storage and read latency
    cyc("R2", 1, 1, 0, 64'h1111_2222_3333_4444);
    cyc("R2", 1, 1, 1, 64'hA5A5_0000_FFFF_0001);
    cyc("R2", 1, 1, 2, 64'h0123_4567_89AB_CDEF);
    cyc("R2", 1, 1, 4, 64'hDEAD_BEEF_0000_0004);
    cyc("R2", 1, 1, 6, 64'h6666_0000_0000_0006);
    for (int i = 0; i < 9; i++) cyc("R2", 1, 0, i, '0);
    cyc("R2", 0, 0, 0, '0);

    // R3 unmapped
    cyc("R3", 1, 0, 9, '0);
    cyc("R3", 1, 1, 0, '0);
    cyc("R3", 1, 0, 31, '0);
    cyc("R3", 1, 1, 9, '1);
    cyc("R3", 1, 1, 31, '1);
    cyc("R3", 1, 0, 2, '0);

    // R10 load, then overrun; R4 read clears full
    cyc("R10", 0, 0, 0, '0, 1, 64'hCAFE_0000_0000_0001);
    cyc("R10", 0, 0, 0, '0, 1, 64'hCAFE_0000_0000_0002);
    cyc("R4", 1, 0, 6, '0);
    cyc("R4", 1, 0, 8, '0);

    // R8 status write effect
    cyc("R8", 1, 1, 8, 64'h0);
    cyc("R8", 1, 1, 8, '1);
    cyc("R8", 1, 0, 8, '0);
    cyc("R8", 1, 1, 8, 64'h0800_0000_0000_0000);
    cyc("R8", 1, 1, 8, 64'h0);

    // R5 / R9 transmit flags
    cyc("R5", 1, 1, 5, 64'h5555_AAAA_5555_AAAA);
    cyc("R9", 0, 0, 0, '0, 0, '0, 1);
    cyc("R9", 0, 0, 0, '0, 0, '0, 1);
    cyc("R5", 1, 1, 5, 64'h0000_0000_0000_0055);
    cyc("R5", 1, 0, 5, '0);

    // R6 reset key
    cyc("R6", 1, 1, 3, 64'h0000_0000_05FF_1234);
    cyc("R6", 1, 1, 3, 64'h0000_0001_0A00_0001);
    cyc("R6", 1, 1, 3, 64'h0000_0000_0A00_0002);
    cyc("R6", 1, 1, 3, 64'h0000_0000_0500_0003);
    cyc("R6", 1, 1, 3, 64'h0000_0000_0B00_0004);
    cyc("R6", 1, 1, 3, 64'h0000_0000_0500_0005);
    cyc("R6", 1, 1, 3, 64'hFFFF_FFFF_FAFF_FFFF);
    cyc("R6", 1, 0, 3, '0);

    // R7 opcode order
    cyc("R7", 1, 1, 7, 64'h0102_0304_0506_0708);
    cyc("R7", 1, 0, 7, '0);

    // R11 collisions
    cyc("R11", 1, 1, 5, 64'h77, 0, '0, 1);
    cyc("R11", 0, 0, 0, '0, 1, 64'h1);
    cyc("R11", 1, 1, 8, 64'h0, 1, 64'h2);
    cyc("R11", 1, 1, 6, 64'hB0B0, 1, 64'h3);
    cyc("R11", 1, 0, 6, '0, 1, 64'h4);
    cyc("R11", 1, 0, 8, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule